// File: doc/BRIEF.md
# Data Address Translation Buffer

This block translates the effective addresses of loads and stores into real addresses. It caches page translations for fixed 4 kB pages in a two-way set-associative array. The low bits of the effective page number select the set, and the remaining bits are stored as the tag. When the translate-enable input is low, the address is used as the real address unchanged. Only in that untranslated mode is a fixed region marked as not cacheable.

A lookup returns a hit or a miss indication in the same cycle, together with the real address. A miss only raises `miss`; the caller suppresses the access.

The block also takes the tags of every data-cache way. It compares each translation way's real page number against each cache tag in parallel. It then selects the result with the translation way that hit, so the cache-way hit vector never waits on the real-address multiplexer.

Maintenance uses one command port with two operands:
- The first operand carries control bits and a page number.
- The second operand carries a page-table entry whose real page number is installed on a load.

Top module: `dtlb_xlate`

## Requirements
- R1: With `lookup_valid`=1 and `xlate_en`=0, the block reports `hit`=1 and `miss`=0, and `real_addr` equals `lookup_ea[55:0]`.
- R2: `cache_inh` is 1 only for an untranslated lookup whose `lookup_ea[31:28]` equals 4'hC. It is 0 for every translated lookup.
- R3: A command with `cmd_rb[11:9]`=3'b001 is a load. It installs effective page number `cmd_rb[63:12]` with real page number `cmd_rs[55:12]`. From the next cycle, a translated lookup of that page hits, with `real_addr` = {that real page number, `lookup_ea[11:0]`}.
- R4: A translated lookup with no valid matching entry gives `miss`=1, `hit`=0, `real_addr`=0, `cache_way_hit`=0 and `cache_inh`=0.
- R5: A command with `cmd_rb[11:9]` not 3'b001 and with `cmd_rb[10]` or `cmd_rb[11]` set invalidates every entry.
- R6: A command with `cmd_rb[11:9]`=3'b000 invalidates only the entry holding page `cmd_rb[63:12]`. Other entries keep translating.
- R7: The set index is the low log2(SETS) bits of the page number, and each set has two ways. Each set holds one replacement bit, reset to 0. A load that does not match an existing entry writes the way named by that bit. A load, or a translated lookup hit, in way w sets the bit to the other way. A load takes priority over a same-cycle lookup for this update.
- R8: Loading a page that is already present rewrites the way that holds it. A page never hits in two ways.
- R9: `cache_way_hit[c]` is 1 for a hit whose real page number (`real_addr[55:12]`) equals cache tag c, held in `cache_tags[c*44 +: 44]`.
- R10: With `lookup_valid`=0, `hit`, `miss`, `real_addr`, `cache_inh` and `cache_way_hit` are all 0.
- R11: After reset, no entry is valid, so every translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_ea | input | 64 | Effective address to translate |
| xlate_en | input | 1 | 1: translate through the buffer; 0: real mode |
| cache_tags | input | 88 | One 44-bit real page tag per data-cache way |
| cmd_valid | input | 1 | Maintenance command present |
| cmd_rb | input | 64 | Control bits [11:9] and effective page number [63:12] |
| cmd_rs | input | 64 | Page-table entry; real page number in [55:12] |
| hit | output | 1 | Lookup resolved to a real address |
| miss | output | 1 | Translated lookup found no entry |
| real_addr | output | 56 | Real address of the lookup |
| cache_inh | output | 1 | Real-mode access to the non-cacheable region |
| cache_way_hit | output | 2 | Per cache way: real page matches that way's tag |

## Verification
The bench builds the block with SETS=8 and two cache ways, leaving the address widths at their defaults. It draws pages from a pool of 64 numbers, including one that differs only in a high tag bit. With so few sets, the random traffic often hits a full set, evicts a way by the replacement bit, reloads a page already present and hits on a page that differs from a resident one only in its upper tag bits. The cache tags are drawn from resident real pages and from the lookup address as often as at random, so both values of each cache-way hit bit occur in both modes.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_INV_ONE, OP_INV_ALL, OP_FILL} tlb_op_e;
  // positions of the control field inside the first command operand
  localparam int unsigned CTL_LSB = 9;
  localparam int unsigned CTL_W   = 3;
endpackage

// File: rtl/dtlb_cmd_dec.sv
module dtlb_cmd_dec
  import dtlb_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CTL_W-1:0] ctl,
  output tlb_op_e          op
);
  always_comb begin
    if (!cmd_valid)            op = OP_IDLE;
    else if (ctl == 3'b001)    op = OP_FILL;
    else if (ctl[2] | ctl[1])  op = OP_INV_ALL;
    else                       op = OP_INV_ONE;
  end
endmodule

// File: rtl/dtlb_way.sv
module dtlb_way #(
  parameter int SETS       = 64,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 46,
  parameter int RPN_W      = 44,
  parameter int CACHE_WAYS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic [TAG_W-1:0]            rd_tag,
  output logic                        rd_hit,
  output logic [RPN_W-1:0]            rd_rpn,
  input  logic [CACHE_WAYS*RPN_W-1:0] cache_tags,
  output logic [CACHE_WAYS-1:0]       ctag_hit,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [TAG_W-1:0]            wr_tag,
  output logic                        wr_match,
  input  logic                        inv_all,
  input  logic                        inv_one,
  input  logic                        fill_en,
  input  logic [RPN_W-1:0]            fill_rpn
);
  logic [SETS-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [RPN_W-1:0] rpn_q [SETS];

  assign wr_match = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

  always_comb begin
    vld_d = vld_q;
    if (inv_all)                  vld_d = '0;
    else if (fill_en)             vld_d[wr_idx] = 1'b1;
    else if (inv_one && wr_match) vld_d[wr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload arrays: write enable only, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[wr_idx] <= wr_tag;
      rpn_q[wr_idx] <= fill_rpn;
    end
  end

  assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_rpn = rpn_q[rd_idx];

  // real page of this way against every cache tag, independent of the way select
  for (genvar c = 0; c < CACHE_WAYS; c++) begin : g_ctag
    assign ctag_hit[c] = rd_hit && (rd_rpn == cache_tags[c*RPN_W +: RPN_W]);
  end

  // R6: a single invalidate that matched leaves the entry empty
  a_r6_inv_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one && !inv_all && !fill_en && wr_match) |=> !vld_q[$past(wr_idx)]);
  // R5: after a full invalidate nothing in the way is valid
  a_r5_way_empty: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0));
endmodule

// File: rtl/dtlb_lru.sv
module dtlb_lru #(
  parameter int SETS  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             victim
);
  logic [SETS-1:0] lru_q, lru_d;

  always_comb begin
    lru_d = lru_q;
    if (touch_en) lru_d[touch_idx] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign victim = lru_q[rd_idx];

  // R7: the touched set now names the other way as victim
  a_r7_lru_points_away: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(touch_idx)] != $past(touch_way)));
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int EA_W       = 64,
  parameter int RA_W       = 56,
  parameter int PG_BITS    = 12,
  parameter int SETS       = 64,
  parameter int CACHE_WAYS = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  lookup_valid,
  input  logic [EA_W-1:0]                       lookup_ea,
  input  logic                                  xlate_en,
  input  logic [CACHE_WAYS*(RA_W-PG_BITS)-1:0]  cache_tags,
  input  logic                                  cmd_valid,
  input  logic [EA_W-1:0]                       cmd_rb,
  input  logic [EA_W-1:0]                       cmd_rs,
  output logic                                  hit,
  output logic                                  miss,
  output logic [RA_W-1:0]                       real_addr,
  output logic                                  cache_inh,
  output logic [CACHE_WAYS-1:0]                 cache_way_hit
);
  localparam int IDX_W = $clog2(SETS);
  localparam int EPN_W = EA_W - PG_BITS;
  localparam int TAG_W = EPN_W - IDX_W;
  localparam int RPN_W = RA_W - PG_BITS;
  localparam int TWAYS = 2;

  logic [EPN_W-1:0] look_epn, cmd_epn;
  logic [IDX_W-1:0] look_idx, cmd_idx;
  logic [TAG_W-1:0] look_tag, cmd_tag;
  assign look_epn = lookup_ea[EA_W-1:PG_BITS];
  assign look_idx = look_epn[IDX_W-1:0];
  assign look_tag = look_epn[EPN_W-1:IDX_W];
  assign cmd_epn  = cmd_rb[EA_W-1:PG_BITS];
  assign cmd_idx  = cmd_epn[IDX_W-1:0];
  assign cmd_tag  = cmd_epn[EPN_W-1:IDX_W];

  logic unused_ok;
  assign unused_ok = ^{cmd_rb[CTL_LSB-1:0], cmd_rs[EA_W-1:RA_W], cmd_rs[PG_BITS-1:0]};

  tlb_op_e op;
  dtlb_cmd_dec u_dec (
    .cmd_valid (cmd_valid),
    .ctl       (cmd_rb[CTL_LSB +: CTL_W]),
    .op        (op)
  );

  logic [TWAYS-1:0]      way_hit, way_wmatch, way_fill;
  logic [RPN_W-1:0]      way_rpn  [TWAYS];
  logic [CACHE_WAYS-1:0] way_ctag [TWAYS];
  logic                  victim, fill_way, hit_way;

  assign fill_way = way_wmatch[1] ? 1'b1 : (way_wmatch[0] ? 1'b0 : victim);
  assign hit_way  = way_hit[1];

  for (genvar w = 0; w < TWAYS; w++) begin : g_way
    assign way_fill[w] = (op == OP_FILL) && (fill_way == w[0]);
    dtlb_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .RPN_W(RPN_W), .CACHE_WAYS(CACHE_WAYS)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (look_idx),
      .rd_tag     (look_tag),
      .rd_hit     (way_hit[w]),
      .rd_rpn     (way_rpn[w]),
      .cache_tags (cache_tags),
      .ctag_hit   (way_ctag[w]),
      .wr_idx     (cmd_idx),
      .wr_tag     (cmd_tag),
      .wr_match   (way_wmatch[w]),
      .inv_all    (op == OP_INV_ALL),
      .inv_one    (op == OP_INV_ONE),
      .fill_en    (way_fill[w]),
      .fill_rpn   (cmd_rs[RA_W-1:PG_BITS])
    );
  end

  logic             touch_en, touch_way;
  logic [IDX_W-1:0] touch_idx;
  always_comb begin
    touch_en  = 1'b0;
    touch_idx = look_idx;
    touch_way = hit_way;
    if (op == OP_FILL) begin
      touch_en  = 1'b1;
      touch_idx = cmd_idx;
      touch_way = fill_way;
    end else if (lookup_valid && xlate_en && (|way_hit)) begin
      touch_en  = 1'b1;
    end
  end

  dtlb_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .touch_way (touch_way),
    .rd_idx    (cmd_idx),
    .victim    (victim)
  );

  always_comb begin
    hit           = 1'b0;
    miss          = 1'b0;
    real_addr     = '0;
    cache_inh     = 1'b0;
    cache_way_hit = '0;
    if (lookup_valid) begin
      if (!xlate_en) begin
        hit       = 1'b1;
        real_addr = lookup_ea[RA_W-1:0];
        cache_inh = (lookup_ea[31:28] == 4'hC);
        for (int c = 0; c < CACHE_WAYS; c++)
          cache_way_hit[c] = (lookup_ea[RA_W-1:PG_BITS] == cache_tags[c*RPN_W +: RPN_W]);
      end else if (|way_hit) begin
        hit       = 1'b1;
        real_addr = {way_rpn[hit_way], lookup_ea[PG_BITS-1:0]};
        for (int c = 0; c < CACHE_WAYS; c++)
          cache_way_hit[c] = way_ctag[0][c] | way_ctag[1][c];
      end else begin
        miss = 1'b1;
      end
    end
  end

  // R8: a page is resident in at most one way
  a_r8_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));
  // R4: a miss carries no cache-way match and no hit
  a_r4_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (!hit && cache_way_hit == '0 && real_addr == '0));
  // R5: a full invalidate leaves no way able to hit
  a_r5_inv_all_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INV_ALL) |=> (way_hit == '0));
  // R3: a page just loaded hits on the next cycle
  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FILL) |=> ((look_epn != $past(cmd_epn)) || (|way_hit)));
  // R1: real mode always resolves
  a_r1_real_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !xlate_en) |-> (hit && !miss));
  // R10: idle lookup port drives nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> (!hit && !miss && !cache_inh && cache_way_hit == '0));
endmodule

// File: tb/test_dtlb_xlate.sv
module test_dtlb_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int SETS_TB    = 8;
  localparam int CW         = 2;
  localparam int RPN_W      = 44;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lookup_valid, xlate_en, cmd_valid;
  logic [63:0]   lookup_ea, cmd_rb, cmd_rs;
  logic [CW*RPN_W-1:0] cache_tags;
  logic          hit, miss, cache_inh;
  logic [55:0]   real_addr;
  logic [CW-1:0] cache_way_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtlb_xlate #(.SETS(SETS_TB), .CACHE_WAYS(CW)) i_dtlb_xlate (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_ea(lookup_ea),
    .xlate_en(xlate_en), .cache_tags(cache_tags), .cmd_valid(cmd_valid),
    .cmd_rb(cmd_rb), .cmd_rs(cmd_rs), .hit(hit), .miss(miss),
    .real_addr(real_addr), .cache_inh(cache_inh), .cache_way_hit(cache_way_hit)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state, built from the requirements
  logic        m_v   [SETS_TB][2];
  logic [51:0] m_epn [SETS_TB][2];
  logic [43:0] m_rpn [SETS_TB][2];
  logic        m_lru [SETS_TB];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rb_fill(logic [51:0] e);    return {e, 12'h200}; endfunction
  function automatic logic [63:0] rb_inv_one(logic [51:0] e); return {e, 12'h000}; endfunction
  function automatic logic [63:0] rs_of(logic [43:0] r);      return {8'hA5, r, 12'h3C1}; endfunction

  task automatic apply(input logic cv, input logic [63:0] rb, input logic [63:0] rs,
                       input logic lv, input logic [63:0] ea, input logic xe,
                       input logic [CW*RPN_W-1:0] ct, input string lbl);
    logic e_hit, e_miss, e_ci, found, fw;
    logic [55:0] e_ra;
    logic [CW-1:0] e_cwh;
    logic [43:0] pg;
    int s, cs;
    string rq;
    @(negedge clk);
    cmd_valid = cv; cmd_rb = rb; cmd_rs = rs;
    lookup_valid = lv; lookup_ea = ea; xlate_en = xe; cache_tags = ct;
    #2;
    e_hit = 0; e_miss = 0; e_ci = 0; e_ra = '0; e_cwh = '0; found = 0; fw = 0; pg = '0;
    s = int'(ea[12 +: 3]);
    rq = "R10";
    if (lv) begin
      if (!xe) begin
        rq = "R1"; e_hit = 1; e_ra = ea[55:0]; e_ci = (ea[31:28] == 4'hC); pg = ea[55:12];
        for (int c = 0; c < CW; c++) e_cwh[c] = (pg == ct[c*RPN_W +: RPN_W]);
      end else begin
        for (int w = 0; w < 2; w++)
          if (m_v[s][w] && m_epn[s][w] == ea[63:12]) begin found = 1; fw = w[0]; end
        if (found) begin
          rq = "R3"; e_hit = 1; pg = m_rpn[s][fw]; e_ra = {pg, ea[11:0]};
          for (int c = 0; c < CW; c++) e_cwh[c] = (pg == ct[c*RPN_W +: RPN_W]);
        end else begin
          rq = "R4"; e_miss = 1;
        end
      end
    end
    chk({lbl, "/", rq}, "hit", 64'(hit), 64'(e_hit));
    chk({lbl, "/", rq}, "miss", 64'(miss), 64'(e_miss));
    chk({lbl, "/", rq}, "real_addr", 64'(real_addr), 64'(e_ra));
    chk({lbl, "/R2"}, "cache_inh", 64'(cache_inh), 64'(e_ci));
    chk({lbl, "/R9"}, "cache_way_hit", 64'(cache_way_hit), 64'(e_cwh));
    // reference update for this edge
    if (cv && rb[11:9] == 3'b001) begin
      cs = int'(rb[12 +: 3]);
      if (m_v[cs][1] && m_epn[cs][1] == rb[63:12])      fw = 1;
      else if (m_v[cs][0] && m_epn[cs][0] == rb[63:12]) fw = 0;
      else                                               fw = m_lru[cs];
      m_v[cs][fw] = 1; m_epn[cs][fw] = rb[63:12]; m_rpn[cs][fw] = rs[55:12];
      m_lru[cs] = ~fw;
    end else begin
      if (lv && xe && found) m_lru[s] = ~fw;
      if (cv && (rb[10] | rb[11])) begin
        for (int a = 0; a < SETS_TB; a++) begin m_v[a][0] = 0; m_v[a][1] = 0; end
      end else if (cv) begin
        cs = int'(rb[12 +: 3]);
        for (int w = 0; w < 2; w++)
          if (m_v[cs][w] && m_epn[cs][w] == rb[63:12]) m_v[cs][w] = 0;
      end
    end
  endtask

  task automatic look(logic [51:0] e, logic xe, logic [CW*RPN_W-1:0] ct, string lbl);
    apply(1'b0, '0, '0, 1'b1, {e, 12'h5A4}, xe, ct, lbl);
  endtask

  function automatic logic [51:0] rnd_epn();
    logic [51:0] e;
    e = 52'($urandom % 32);
    if ($urandom % 2 == 1) e[45] = 1'b1;
    return e;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [43:0] ra, rb2, rc;
    logic [CW*RPN_W-1:0] ct;
    void'($urandom(32'd7391));
    for (int a = 0; a < SETS_TB; a++) begin
      m_v[a][0] = 0; m_v[a][1] = 0; m_lru[a] = 0;
      m_epn[a][0] = '0; m_epn[a][1] = '0; m_rpn[a][0] = '0; m_rpn[a][1] = '0;
    end
    rst_n = 1'b0; cmd_valid = 0; lookup_valid = 0; xlate_en = 0;
    cmd_rb = '0; cmd_rs = '0; lookup_ea = '0; cache_tags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    ra = 44'hAAA_0001_2345; rb2 = 44'hBBB_0002_3456; rc = 44'hCCC_0003_4567;
    // R11: empty after reset
    look(52'h9, 1'b1, '0, "R11");
    look(52'h2000_0000_0005, 1'b1, '0, "R11");
    // R10: idle port
    apply(1'b0, '0, '0, 1'b0, 64'hFFFF_FFFF_C000_0000, 1'b0, '0, "R10");
    // R3 / R9: load and hit, tag matches cache way 1 only
    apply(1'b1, rb_fill(52'h9), rs_of(ra), 1'b0, '0, 1'b1, '0, "R3");
    look(52'h9, 1'b1, {ra, 44'h1}, "R3");
    look(52'h9, 1'b1, {ra, ra}, "R9");
    // R7: fill B into the other way, touch A, then C evicts B
    apply(1'b1, rb_fill(52'h11), rs_of(rb2), 1'b0, '0, 1'b1, '0, "R7");
    look(52'h11, 1'b1, '0, "R7");
    look(52'h9, 1'b1, '0, "R7");
    apply(1'b1, rb_fill(52'h19), rs_of(rc), 1'b0, '0, 1'b1, '0, "R7");
    look(52'h11, 1'b1, '0, "R7");
    look(52'h9, 1'b1, '0, "R7");
    look(52'h19, 1'b1, {44'h0, rc}, "R7");
    // R8: reload a resident page with a new real page
    apply(1'b1, rb_fill(52'h19), rs_of(44'h123), 1'b0, '0, 1'b1, '0, "R8");
    look(52'h19, 1'b1, '0, "R8");
    look(52'h9, 1'b1, '0, "R8");
    // R6: single invalidate removes only A
    apply(1'b1, rb_inv_one(52'h9), '0, 1'b0, '0, 1'b1, '0, "R6");
    look(52'h9, 1'b1, '0, "R6");
    look(52'h19, 1'b1, '0, "R6");
    // R5: whole invalidate, both scope bits and the 111 code
    apply(1'b1, 64'hE00, '0, 1'b0, '0, 1'b1, '0, "R5");
    look(52'h19, 1'b1, '0, "R5");
    apply(1'b1, rb_fill(52'h3), rs_of(ra), 1'b0, '0, 1'b1, '0, "R5");
    apply(1'b1, {52'h3, 12'h800}, '0, 1'b0, '0, 1'b1, '0, "R5");
    look(52'h3, 1'b1, '0, "R5");
    // R2: non-cacheable region only in real mode
    apply(1'b0, '0, '0, 1'b1, 64'h0000_0000_C000_1234, 1'b0, {44'hC0001, 44'h0}, "R2");
    apply(1'b1, rb_fill(52'hC0001), rs_of(ra), 1'b0, '0, 1'b1, '0, "R2");
    apply(1'b0, '0, '0, 1'b1, 64'h0000_0000_C000_1234, 1'b1, '0, "R2");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic cv, lv, xe;
      logic [63:0] rb, rs, ea;
      logic [51:0] le;
      int k, s;
      cv = ($urandom % 10) < 3;
      k = $urandom % 20;
      rb = {rnd_epn(), 3'b000, 9'($urandom)};
      if (k < 12)      rb[11:9] = 3'b001;
      else if (k < 17) rb[11:9] = 3'b000;
      else             rb[11:9] = {2'(1 + $urandom % 3), 1'($urandom)};
      rs = {$urandom, $urandom};
      lv = ($urandom % 10) < 8;
      xe = ($urandom % 4) != 0;
      le = rnd_epn();
      ea = {le, 12'($urandom)};
      if (!xe) begin
        ea = {$urandom, $urandom};
        if ($urandom % 4 == 0) ea[31:28] = 4'hC;
      end
      s = int'(ea[12 +: 3]);
      for (int c = 0; c < CW; c++) begin
        case ($urandom % 3)
          0:       ct[c*RPN_W +: RPN_W] = {12'($urandom), $urandom};
          1:       ct[c*RPN_W +: RPN_W] = m_rpn[s][c % 2];
          default: ct[c*RPN_W +: RPN_W] = ea[55:12];
        endcase
      end
      apply(cv, rb, rs, lv, ea, xe, ct, "rand");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule